// File: doc/BRIEF.md
# Interrupt Enable and Delegation Register Unit

This block keeps the 64-bit interrupt-enable register of the machine level together with the two interrupt-delegation registers: one that hands interrupts from machine to supervisor level, and one that hands them from hypervisor to guest-supervisor level. Software reaches this state through one read-modify-write port. Each access gives a 12-bit register address, a new value and a write mask. In the same cycle the port returns the old contents and an illegal-access flag. The update takes effect on the next rising clock edge.

The supervisor, hypervisor and guest-supervisor enable views are not separate storage. They are filtered windows onto the single machine enable register. The guest view relocates the guest-level software, timer and external bits so that they appear one position lower. When XLEN is 32, the upper half of each 64-bit register is reached through a separate high-half address. Five configuration inputs decide which views exist and how they behave:

- hypervisor extension present
- supervisor extension present
- extended interrupt support enabled
- XLEN is 32
- hart runs virtualized

Top module: `irq_csr_unit`

## Requirements
- R1: A legal valid access returns the register contents from before the access. On the next rising edge it changes only the bits that are set both in the write mask and in that view's writable set. A valid access with a zero write mask leaves the state unchanged, apart from the forced and cleared bits named in R4 and R5.
- R2: A high-half access places the 32-bit new value and write mask at bits 63:32 and returns bits 63:32 of the old value. All writable bits sit below bit 32, so such an access reads zero and changes no writable bit.
- R3: A high-half address is illegal unless extended interrupt support is on and XLEN is 32. The following additional conditions apply:
  - The supervisor high half also needs the supervisor extension.
  - The delegation and guest high halves also need both the hypervisor and supervisor extensions.
- R4: The writable bits of the machine delegation register are the supervisor and guest bits {1,2,5,6,9,10}. When the hypervisor extension is present, every legal access to it (low or high half) then forces bits {2,6,10,12} to 1.
- R5: The writable bits of the machine enable register are {1,2,3,5,6,7,9,10,11,12}. When the hypervisor extension is absent, bit 12 is cleared by every legal access that targets this register through any view.
- R6: Outside virtualized mode, the supervisor enable view (address 0x104) can write only bits {1,5,9} that are also set in the machine delegation register. Its read value is masked by the same set.
- R7: In virtualized mode, the supervisor enable view behaves as the guest enable view. Its read value is additionally masked by the machine delegation bits {1,5,9}.
- R8: The guest enable view (address 0x204) handles writes and reads as follows:
  - On write, incoming bits {1,5,9} move up to {2,6,10}. They are ORed with incoming bits already at {2,6,10}, for both the value and the mask.
  - Only the bits {2,6,10} that are set in the hypervisor delegation register are written.
  - On read, the delegated bits {2,6,10} are returned at {1,5,9}.
- R9: The hypervisor delegation register (address 0x603) holds only bits {2,6,10}. The hypervisor enable view (address 0x604) reads and writes only bits {2,6,10,12} of the machine enable register.
- R10: The following accesses are illegal:
  - an unknown address;
  - the supervisor view without the supervisor extension;
  - the hypervisor-level views without both the hypervisor and supervisor extensions.

  An illegal access returns zero, raises the illegal flag and changes no state.
- R11: After reset all three registers are zero. With no valid access the state holds, and both the read data and the illegal flag are zero.
- R12: When XLEN is 32, bits 63:32 of the read data of every access are zero.

Address map: machine delegation 0x303 / high 0x313, machine enable 0x304 / high 0x314, supervisor enable 0x104 / high 0x114, hypervisor delegation 0x603 / high 0x613, hypervisor enable 0x604, guest enable 0x204 / high 0x214.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 12 | Register address |
| acc_wdata | input | 64 | New value |
| acc_wmask | input | 64 | Write mask |
| cfg_has_h | input | 1 | Hypervisor extension present |
| cfg_has_s | input | 1 | Supervisor extension present |
| cfg_ext_irq | input | 1 | Extended interrupt support enabled |
| cfg_xlen32 | input | 1 | XLEN is 32 |
| cfg_virt | input | 1 | Hart in virtualized mode |
| acc_rdata | output | 64 | Old contents of the addressed view |
| acc_illegal | output | 1 | Access is illegal |

## Verification
The hardest condition to reach is a set guest-external enable bit (bit 12) that an access then clears because the hypervisor extension has gone away. This needs three steps in order:

1. set bit 12 while the extension is present;
2. flip the configuration;
3. touch the register through a view that cannot itself write bit 12, such as the high half.

The directed part of the stimulus walks this sequence. It also covers the other cross-register paths: a virtualized supervisor access that is filtered by both delegation registers, and a guest write whose mask carries bits already in guest position. Seeded random accesses then mix all addresses, configurations and masks against a bench model.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;

    localparam int REG_W  = 64;
    localparam int ADDR_W = 12;

    // interrupt bit positions
    localparam int B_SSW  = 1;
    localparam int B_VSW  = 2;
    localparam int B_MSW  = 3;
    localparam int B_STM  = 5;
    localparam int B_VTM  = 6;
    localparam int B_MTM  = 7;
    localparam int B_SEX  = 9;
    localparam int B_VEX  = 10;
    localparam int B_MEX  = 11;
    localparam int B_GEX  = 12;

    localparam logic [REG_W-1:0] SUP_SET  = (REG_W'(1) << B_SSW) | (REG_W'(1) << B_STM) | (REG_W'(1) << B_SEX);
    localparam logic [REG_W-1:0] GST_SET  = (REG_W'(1) << B_VSW) | (REG_W'(1) << B_VTM) | (REG_W'(1) << B_VEX);
    localparam logic [REG_W-1:0] MCH_SET  = (REG_W'(1) << B_MSW) | (REG_W'(1) << B_MTM) | (REG_W'(1) << B_MEX);
    localparam logic [REG_W-1:0] HYP_SET  = GST_SET | (REG_W'(1) << B_GEX);
    localparam logic [REG_W-1:0] DLG_SET  = SUP_SET | GST_SET;
    localparam logic [REG_W-1:0] ENA_SET  = MCH_SET | SUP_SET | HYP_SET;

    // register addresses
    localparam logic [ADDR_W-1:0] A_MDLG    = 12'h303;
    localparam logic [ADDR_W-1:0] A_MDLG_HI = 12'h313;
    localparam logic [ADDR_W-1:0] A_MENA    = 12'h304;
    localparam logic [ADDR_W-1:0] A_MENA_HI = 12'h314;
    localparam logic [ADDR_W-1:0] A_SENA    = 12'h104;
    localparam logic [ADDR_W-1:0] A_SENA_HI = 12'h114;
    localparam logic [ADDR_W-1:0] A_HDLG    = 12'h603;
    localparam logic [ADDR_W-1:0] A_HDLG_HI = 12'h613;
    localparam logic [ADDR_W-1:0] A_HENA    = 12'h604;
    localparam logic [ADDR_W-1:0] A_GENA    = 12'h204;
    localparam logic [ADDR_W-1:0] A_GENA_HI = 12'h214;

    // storage indices
    localparam int NUM_REGS = 3;
    localparam int IX_ENA   = 0;
    localparam int IX_MDLG  = 1;
    localparam int IX_HDLG  = 2;

    typedef enum logic [2:0] {
        VW_NONE, VW_MDLG, VW_MENA, VW_SENA, VW_HDLG, VW_HENA, VW_GENA
    } view_e;

    typedef struct packed {
        view_e view;
        logic  hi;
        logic  redir;
        logic  legal;
    } dec_t;

    typedef struct packed {
        logic has_h;
        logic has_s;
        logic ext_irq;
        logic xlen32;
        logic virt;
    } cfg_t;

    function automatic logic [REG_W-1:0] merge_bits(input logic [REG_W-1:0] cur,
                                                    input logic [REG_W-1:0] nv,
                                                    input logic [REG_W-1:0] msk);
        return (cur & ~msk) | (nv & msk);
    endfunction

    // supervisor positions lifted to guest positions, ORed over the rest
    function automatic logic [REG_W-1:0] lift_gst(input logic [REG_W-1:0] x);
        return (x & ~SUP_SET) | ((x & SUP_SET) << 1);
    endfunction

    function automatic logic [REG_W-1:0] drop_gst(input logic [REG_W-1:0] x);
        return (x & GST_SET) >> 1;
    endfunction

endpackage

// File: rtl/irq_csr_decode.sv
module irq_csr_decode
    import irq_csr_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    input  cfg_t          cfg,
    output dec_t          dec
);
    logic hi_ok, hyp_ok;

    always_comb begin
        hi_ok  = cfg.ext_irq & cfg.xlen32;
        hyp_ok = cfg.has_h & cfg.has_s;
        dec    = '{view: VW_NONE, hi: 1'b0, redir: 1'b0, legal: 1'b0};
        unique case (addr)
            A_MDLG:    dec = '{view: VW_MDLG, hi: 1'b0, redir: 1'b0, legal: 1'b1};
            A_MDLG_HI: dec = '{view: VW_MDLG, hi: 1'b1, redir: 1'b0, legal: hi_ok};
            A_MENA:    dec = '{view: VW_MENA, hi: 1'b0, redir: 1'b0, legal: 1'b1};
            A_MENA_HI: dec = '{view: VW_MENA, hi: 1'b1, redir: 1'b0, legal: hi_ok};
            A_SENA:    dec = '{view: cfg.virt ? VW_GENA : VW_SENA, hi: 1'b0,
                               redir: cfg.virt, legal: cfg.has_s};
            A_SENA_HI: dec = '{view: cfg.virt ? VW_GENA : VW_SENA, hi: 1'b1,
                               redir: cfg.virt, legal: hi_ok & cfg.has_s};
            A_HDLG:    dec = '{view: VW_HDLG, hi: 1'b0, redir: 1'b0, legal: hyp_ok};
            A_HDLG_HI: dec = '{view: VW_HDLG, hi: 1'b1, redir: 1'b0, legal: hi_ok & hyp_ok};
            A_HENA:    dec = '{view: VW_HENA, hi: 1'b0, redir: 1'b0, legal: hyp_ok};
            A_GENA:    dec = '{view: VW_GENA, hi: 1'b0, redir: 1'b0, legal: hyp_ok};
            A_GENA_HI: dec = '{view: VW_GENA, hi: 1'b1, redir: 1'b0, legal: hi_ok & hyp_ok};
            default:   dec = '{view: VW_NONE, hi: 1'b0, redir: 1'b0, legal: 1'b0};
        endcase
    end
endmodule

// File: rtl/irq_csr_datapath.sv
module irq_csr_datapath
    import irq_csr_pkg::*;
#(
    parameter int W = REG_W,
    parameter int N = NUM_REGS
) (
    input  dec_t                dec,
    input  cfg_t                cfg,
    input  logic [W-1:0]        wdata,
    input  logic [W-1:0]        wmask,
    input  logic [N-1:0][W-1:0] cur,
    output logic [N-1:0][W-1:0] nxt,
    output logic [N-1:0]        upd,
    output logic [W-1:0]        rdata
);
    localparam int HALF = W / 2;

    logic [W-1:0] nv, wm, src, emask, old;
    logic [W-1:0] ena, mdlg, hdlg;
    logic         ena_tgt;

    always_comb begin
        ena  = cur[IX_ENA];
        mdlg = cur[IX_MDLG];
        hdlg = cur[IX_HDLG];

        // place the port value into the 64-bit register frame
        if (dec.hi) begin
            nv = {wdata[HALF-1:0], {HALF{1'b0}}};
            wm = {wmask[HALF-1:0], {HALF{1'b0}}};
        end else if (cfg.xlen32) begin
            nv = {{HALF{1'b0}}, wdata[HALF-1:0]};
            wm = {{HALF{1'b0}}, wmask[HALF-1:0]};
        end else begin
            nv = wdata;
            wm = wmask;
        end

        old     = '0;
        src     = nv;
        emask   = '0;
        ena_tgt = 1'b0;
        nxt     = cur;
        upd     = '0;

        unique case (dec.view)
            VW_MDLG: begin
                old           = mdlg;
                nxt[IX_MDLG]  = merge_bits(mdlg, nv, wm & DLG_SET);
                if (cfg.has_h) nxt[IX_MDLG] = nxt[IX_MDLG] | HYP_SET;
                upd[IX_MDLG]  = 1'b1;
            end
            VW_MENA: begin
                old     = ena;
                emask   = wm & ENA_SET;
                ena_tgt = 1'b1;
            end
            VW_SENA: begin
                old     = ena & mdlg & SUP_SET;
                emask   = wm & mdlg & SUP_SET;
                ena_tgt = 1'b1;
            end
            VW_HDLG: begin
                old           = hdlg & GST_SET;
                nxt[IX_HDLG]  = merge_bits(hdlg, nv, wm & GST_SET);
                upd[IX_HDLG]  = 1'b1;
            end
            VW_HENA: begin
                old     = ena & HYP_SET;
                emask   = wm & HYP_SET;
                ena_tgt = 1'b1;
            end
            VW_GENA: begin
                src     = lift_gst(nv);
                emask   = lift_gst(wm) & hdlg & GST_SET;
                old     = drop_gst(ena & hdlg);
                if (dec.redir) old = old & mdlg & SUP_SET;
                ena_tgt = 1'b1;
            end
            default: ;
        endcase

        if (ena_tgt) begin
            nxt[IX_ENA] = merge_bits(ena, src, emask);
            if (!cfg.has_h) nxt[IX_ENA][B_GEX] = 1'b0;
            upd[IX_ENA] = 1'b1;
        end

        rdata = dec.hi ? (old >> HALF) : old;
        if (cfg.xlen32) rdata[W-1:HALF] = '0;

        if (!dec.legal) begin
            rdata = '0;
            upd   = '0;
        end
    end
endmodule

// File: rtl/irq_csr_reg.sv
module irq_csr_reg #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/irq_csr_unit.sv
module irq_csr_unit
    import irq_csr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int W  = REG_W,
    parameter int N  = NUM_REGS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_valid,
    input  logic [AW-1:0] acc_addr,
    input  logic [W-1:0]  acc_wdata,
    input  logic [W-1:0]  acc_wmask,
    input  logic          cfg_has_h,
    input  logic          cfg_has_s,
    input  logic          cfg_ext_irq,
    input  logic          cfg_xlen32,
    input  logic          cfg_virt,
    output logic [W-1:0]  acc_rdata,
    output logic          acc_illegal
);
    cfg_t                cfg;
    dec_t                dec;
    logic [N-1:0][W-1:0] state_q;
    logic [N-1:0][W-1:0] state_d;
    logic [N-1:0]        upd;
    logic [W-1:0]        dp_rdata;

    assign cfg = '{has_h: cfg_has_h, has_s: cfg_has_s, ext_irq: cfg_ext_irq,
                   xlen32: cfg_xlen32, virt: cfg_virt};

    irq_csr_decode #(.AW(AW)) u_dec (
        .addr (acc_addr),
        .cfg  (cfg),
        .dec  (dec)
    );

    irq_csr_datapath #(.W(W), .N(N)) u_dp (
        .dec   (dec),
        .cfg   (cfg),
        .wdata (acc_wdata),
        .wmask (acc_wmask),
        .cur   (state_q),
        .nxt   (state_d),
        .upd   (upd),
        .rdata (dp_rdata)
    );

    for (genvar i = 0; i < N; i++) begin : g_reg
        irq_csr_reg #(.W(W)) u_reg (
            .clk  (clk),
            .rst  (rst),
            .load (acc_valid & upd[i]),
            .d    (state_d[i]),
            .q    (state_q[i])
        );
    end

    assign acc_rdata   = acc_valid ? dp_rdata : '0;
    assign acc_illegal = acc_valid & ~dec.legal;
endmodule

// File: rtl/irq_csr_unit_chk.sv
module irq_csr_unit_chk
    import irq_csr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [REG_W-1:0]  acc_rdata,
    input logic              acc_illegal,
    input logic              cfg_has_h,
    input logic              cfg_ext_irq,
    input logic              cfg_xlen32,
    input logic [REG_W-1:0]  st_ena,
    input logic [REG_W-1:0]  st_mdlg,
    input logic [REG_W-1:0]  st_hdlg
);
    logic hi_addr, mdlg_addr, ena_addr;
    assign hi_addr   = (acc_addr == A_MDLG_HI) || (acc_addr == A_MENA_HI) ||
                       (acc_addr == A_SENA_HI) || (acc_addr == A_HDLG_HI) ||
                       (acc_addr == A_GENA_HI);
    assign mdlg_addr = (acc_addr == A_MDLG) || (acc_addr == A_MDLG_HI);
    assign ena_addr  = (acc_addr == A_MENA) || (acc_addr == A_MENA_HI);

    // R10: illegal access reads zero
    p_illegal_zero_r10: assert property (@(posedge clk) disable iff (rst)
        acc_illegal |-> (acc_rdata == '0));

    // R10: illegal access leaves state untouched
    p_illegal_hold_r10: assert property (@(posedge clk) disable iff (rst)
        acc_illegal |=> ($stable(st_ena) && $stable(st_mdlg) && $stable(st_hdlg)));

    // R11: no access, no change
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> ($stable(st_ena) && $stable(st_mdlg) && $stable(st_hdlg)));

    // R3: high halves need extended interrupts and XLEN 32
    p_hi_gate_r3: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && hi_addr && !(cfg_ext_irq && cfg_xlen32)) |-> acc_illegal);

    // R9: hypervisor delegation holds guest bits only
    p_hdlg_legal_r9: assert property (@(posedge clk) disable iff (rst)
        (st_hdlg & ~GST_SET) == '0);

    // R5: enable register holds only its writable set
    p_ena_legal_r5: assert property (@(posedge clk) disable iff (rst)
        (st_ena & ~ENA_SET) == '0);

    // R4: delegation register holds only delegable and forced bits
    p_mdlg_legal_r4: assert property (@(posedge clk) disable iff (rst)
        (st_mdlg & ~(DLG_SET | HYP_SET)) == '0);

    // R4: forced bits after an access with the hypervisor present
    p_force_hyp_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_illegal && mdlg_addr && cfg_has_h) |=> ((st_mdlg & HYP_SET) == HYP_SET));

    // R5: guest-external enable cleared without the hypervisor
    p_gex_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_illegal && ena_addr && !cfg_has_h) |=> !st_ena[B_GEX]);

    // R12: upper read half zero under XLEN 32
    p_upper_zero_r12: assert property (@(posedge clk) disable iff (rst)
        cfg_xlen32 |-> (acc_rdata[REG_W-1:REG_W/2] == '0));
endmodule

bind irq_csr_unit irq_csr_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .acc_valid   (acc_valid),
    .acc_addr    (acc_addr),
    .acc_rdata   (acc_rdata),
    .acc_illegal (acc_illegal),
    .cfg_has_h   (cfg_has_h),
    .cfg_ext_irq (cfg_ext_irq),
    .cfg_xlen32  (cfg_xlen32),
    .st_ena      (state_q[0]),
    .st_mdlg     (state_q[1]),
    .st_hdlg     (state_q[2])
);

// File: tb/sim_irq_csr_unit.sv
`timescale 1ns/1ps
module sim_irq_csr_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [63:0] acc_wdata = '0;
    logic [63:0] acc_wmask = '0;
    logic        cfg_has_h = 1'b1, cfg_has_s = 1'b1, cfg_ext_irq = 1'b1;
    logic        cfg_xlen32 = 1'b0, cfg_virt = 1'b0;
    logic [63:0] acc_rdata;
    logic        acc_illegal;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench model state
    logic [63:0] m_ena = '0, m_md = '0, m_hd = '0;

    always #10 clk = ~clk;

    irq_csr_unit u0 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_wmask(acc_wmask),
        .cfg_has_h(cfg_has_h), .cfg_has_s(cfg_has_s), .cfg_ext_irq(cfg_ext_irq),
        .cfg_xlen32(cfg_xlen32), .cfg_virt(cfg_virt),
        .acc_rdata(acc_rdata), .acc_illegal(acc_illegal)
    );

    localparam logic [63:0] S_B = 64'h222, G_B = 64'h444, H_B = 64'h1444;
    localparam logic [63:0] E_B = 64'h1EEE, D_B = 64'h666;

    task automatic model(input logic [11:0] a, input logic [63:0] d, input logic [63:0] m,
                         output logic [63:0] rd, output bit ill,
                         output logic [63:0] ne, output logic [63:0] nm, output logic [63:0] nh);
        int kind; bit hi, ok, rdr, ena_hit;
        logic [63:0] nv, wm, msk, r;
        kind = 0; hi = 0; rdr = 0; ena_hit = 0; msk = '0; r = '0;
        ne = m_ena; nm = m_md; nh = m_hd;
        case (a)
            12'h303: kind = 1;  12'h313: begin kind = 1; hi = 1; end
            12'h304: kind = 2;  12'h314: begin kind = 2; hi = 1; end
            12'h104: kind = 3;  12'h114: begin kind = 3; hi = 1; end
            12'h603: kind = 4;  12'h613: begin kind = 4; hi = 1; end
            12'h604: kind = 5;
            12'h204: kind = 6;  12'h214: begin kind = 6; hi = 1; end
            default: kind = 0;
        endcase
        ok = hi ? (cfg_ext_irq && cfg_xlen32) : 1'b1;
        if (kind == 0) ok = 0;
        if (kind == 3) ok = ok && cfg_has_s;
        if (kind >= 4) ok = ok && cfg_has_h && cfg_has_s;
        if (!ok) begin rd = '0; ill = 1; return; end
        ill = 0;
        if (hi)              begin nv = d << 32; wm = m << 32; end
        else if (cfg_xlen32) begin nv = d & 64'hFFFF_FFFF; wm = m & 64'hFFFF_FFFF; end
        else                 begin nv = d; wm = m; end
        if (kind == 3 && cfg_virt) begin kind = 6; rdr = 1; end
        case (kind)
            1: begin r = m_md; nm = (m_md & ~(wm & D_B)) | (nv & wm & D_B);
                     if (cfg_has_h) nm = nm | H_B; end
            2: begin r = m_ena; msk = wm & E_B; ena_hit = 1; end
            3: begin r = m_ena & m_md & S_B; msk = wm & m_md & S_B; ena_hit = 1; end
            4: begin r = m_hd & G_B; nh = (m_hd & ~(wm & G_B)) | (nv & wm & G_B); end
            5: begin r = m_ena & H_B; msk = wm & H_B; ena_hit = 1; end
            default: begin
                nv  = (nv & ~S_B) | ((nv & S_B) << 1);
                msk = ((wm & ~S_B) | ((wm & S_B) << 1)) & m_hd & G_B;
                r   = (m_ena & m_hd & G_B) >> 1;
                if (rdr) r = r & m_md & S_B;
                ena_hit = 1;
            end
        endcase
        if (ena_hit) begin
            ne = (m_ena & ~msk) | (nv & msk);
            if (!cfg_has_h) ne[12] = 1'b0;
        end
        rd = hi ? (r >> 32) : r;
        if (cfg_xlen32) rd[63:32] = '0;
    endtask

    task automatic acc(input logic [11:0] a, input logic [63:0] d, input logic [63:0] m,
                       input string req);
        logic [63:0] erd, ne, nm, nh; bit eill;
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_wdata = d; acc_wmask = m;
        #1;
        model(a, d, m, erd, eill, ne, nm, nh);
        n_chk++;
        if (acc_rdata !== erd || acc_illegal !== eill) begin
            n_bad++;
            $display("FAIL %s addr=%h rdata=%h ill=%0b expected rdata=%h ill=%0b",
                     req, a, acc_rdata, acc_illegal, erd, eill);
        end
        @(posedge clk);
        #1;
        acc_valid = 1'b0;
        m_ena = ne; m_md = nm; m_hd = nh;
    endtask

    task automatic expect_val(input logic [63:0] act, input logic [63:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic setcfg(input logic h, input logic s, input logic e,
                          input logic x, input logic v);
        @(negedge clk);
        cfg_has_h = h; cfg_has_s = s; cfg_ext_irq = e; cfg_xlen32 = x; cfg_virt = v;
    endtask

    function automatic logic [11:0] pick_addr(input int k);
        case (k)
            0: return 12'h303;  1: return 12'h313;  2: return 12'h304;
            3: return 12'h314;  4: return 12'h104;  5: return 12'h114;
            6: return 12'h603;  7: return 12'h613;  8: return 12'h604;
            9: return 12'h204;  10: return 12'h214; default: return 12'h7C0;
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R11: reset values and idle outputs
        @(negedge clk);
        expect_val({63'b0, acc_illegal}, 64'd0, "R11 idle illegal");
        expect_val(acc_rdata, 64'd0, "R11 idle rdata");
        acc(12'h303, 64'd0, 64'd0, "R11 reset deleg");
        acc(12'h304, 64'd0, 64'd0, "R11 reset enable");

        // R4: delegation writable set and forced bits
        acc(12'h303, '1, '1, "R4 write all");
        acc(12'h303, 64'd0, 64'd0, "R4 forced readback");
        expect_val(m_md, 64'h1666, "R4 model agrees");
        setcfg(0, 1, 1, 0, 0);
        acc(12'h303, 64'd0, '1, "R4 clear no hyp");
        acc(12'h303, 64'd0, 64'd0, "R4 readback no hyp");

        // R5: enable writable set, then bit 12 dropped by a high-half touch
        setcfg(1, 1, 1, 0, 0);
        acc(12'h304, '1, '1, "R5 write all");
        acc(12'h304, 64'd0, 64'd0, "R5 readback 1EEE");
        setcfg(0, 1, 1, 1, 0);
        acc(12'h314, 64'hFFFF_FFFF, 64'hFFFF_FFFF, "R2 high half write reads zero");
        acc(12'h304, 64'd0, 64'd0, "R5 gex cleared 0EEE");

        // R3: high-half gating
        setcfg(1, 1, 1, 0, 0);
        acc(12'h314, 64'd0, 64'd0, "R3 high with xlen64");
        setcfg(1, 1, 0, 1, 0);
        acc(12'h313, 64'd0, 64'd0, "R3 high without ext irq");
        setcfg(1, 0, 1, 1, 0);
        acc(12'h114, 64'd0, 64'd0, "R3 sup high without S");
        setcfg(0, 1, 1, 1, 0);
        acc(12'h613, 64'd0, 64'd0, "R3 hyp high without H");

        // R10: illegal leaves state intact
        setcfg(1, 1, 1, 0, 0);
        acc(12'h7C0, '1, '1, "R10 unknown address");
        setcfg(1, 0, 1, 0, 0);
        acc(12'h104, '1, '1, "R10 sup view without S");
        setcfg(0, 1, 1, 0, 0);
        acc(12'h603, '1, '1, "R10 hyp view without H");
        setcfg(1, 1, 1, 0, 0);
        acc(12'h304, 64'd0, 64'd0, "R10 enable unchanged");

        // R6: supervisor view filtered by delegation
        acc(12'h304, 64'd0, '1, "R1 clear enable");
        acc(12'h303, 64'h2, D_B, "R6 delegate only bit1");
        acc(12'h104, '1, '1, "R6 sup write all");
        acc(12'h304, 64'd0, 64'd0, "R6 enable shows delegated bits");
        acc(12'h104, 64'd0, 64'd0, "R6 sup read masked");

        // R9: hypervisor delegation and enable view
        acc(12'h603, '1, '1, "R9 hdeleg write all");
        acc(12'h603, 64'd0, 64'd0, "R9 hdeleg readback");
        acc(12'h604, '1, '1, "R9 hyp enable write");
        acc(12'h604, 64'd0, 64'd0, "R9 hyp enable readback");

        // R8: guest view shifting
        acc(12'h304, 64'd0, '1, "R1 clear enable");
        acc(12'h603, 64'h40, '1, "R8 hdeleg timer only");
        acc(12'h204, 64'h222, 64'h222, "R8 guest write shifted");
        acc(12'h304, 64'd0, 64'd0, "R8 enable bit6 only");
        acc(12'h204, 64'd0, 64'd0, "R8 guest read shifted down");
        acc(12'h603, 64'h444, '1, "R8 hdeleg all guest");
        acc(12'h204, 64'h4, 64'h4, "R8 unshifted mask bit2");
        acc(12'h304, 64'd0, 64'd0, "R8 enable bit2 set");

        // R7: virtualized supervisor access
        acc(12'h303, 64'h20, D_B, "R7 deleg sup timer");
        setcfg(1, 1, 1, 0, 1);
        acc(12'h104, 64'h200, 64'h200, "R7 redirect write");
        acc(12'h104, 64'd0, 64'd0, "R7 redirect read masked");
        acc(12'h304, 64'd0, 64'd0, "R7 enable after redirect");

        // R12: upper read half zero in 32-bit mode
        setcfg(1, 1, 1, 1, 0);
        acc(12'h304, '1, '1, "R12 xlen32 enable read");
        acc(12'h303, 64'd0, 64'd0, "R12 xlen32 deleg read");

        // R1: random mix
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] d, m;
            if (i % 40 == 0)
                setcfg($urandom_range(0, 3) != 0, $urandom_range(0, 4) != 0,
                       $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
            d = {$urandom, $urandom};
            case ($urandom_range(0, 3))
                0: m = '1;
                1: m = '0;
                default: m = {$urandom, $urandom};
            endcase
            acc(pick_addr($urandom_range(0, 11)), d, m, "R1 random");
        end

        finish_run();
    end
endmodule